// File: doc/BRIEF.md
# Resonant Injection Firing Sequencer

This block drives the two thyristor groups of a DC switch that breaks current by injecting a resonant current into the arcing contact gap. The injection capacitor is not pre-charged. Instead, group 1 charges it from the arc voltage. Group 2 then rings it through a half period, which reverses its polarity. Alternating the two groups pumps the capacitor up until the injected current cancels the load current and the arc goes out. Each group is a pair of antiparallel thyristors sharing one gate pulse, so a single pulse per group covers either current direction.

Once the arc is detected, the sequencer waits a dead time so that the self-powered supply can settle. It then fires group 1 and group 2 in turn. Before each group-2 firing it checks that group 1 has stopped conducting. It stops in any of these cases:
- the gap voltage stays above the high threshold, which means success;
- the supply drops;
- the blocking check times out;
- the number of pulse pairs runs past its limit.

If the arc restrikes after success, pumping restarts with group 2 first. Every interval is a cycle count set by a parameter.

Top module: `inj_fire_seq`

## Requirements
- R1: After reset, all four outputs (fire_g1, fire_g2, done, fail) are low and the block is idle.
- R2: A sequence starts only on a cycle where arc_det and sup_ok are both high. arc_det while sup_ok is low has no effect. The first fire_g1 pulse begins exactly DEAD_CYC cycles after the sequence starts.
- R3: Every firing pulse, on either output, is high for exactly PULSE_CYC consecutive cycles.
- R4: After a group-1 pulse, the block waits HALF_CYC cycles and then fires group 2 on the cycle after g1_block is seen high. fire_g1 and fire_g2 are never high together.
- R5: If g1_block stays low for BLK_TMO_CYC cycles of the blocking check, fail rises and group 2 is never fired.
- R6: After each group-2 pulse, the block waits HALF_CYC cycles and then fires group 1 again. When MAX_PAIRS pairs have completed since the sequence start or restart, fail rises in place of the next group-1 pulse.
- R7: A low sup_ok in any state except idle and fail raises fail on the next cycle. fail stays high until reset.
- R8: gap_hi high during the dead time or pumping stops all firing on the next cycle. done rises after gap_hi has been high for HOLD_CYC consecutive cycles.
- R9: done stays high only while gap_hi stays high. If gap_hi drops while done is high (restrike), the next cycle starts a group-2 pulse, and the pair count starts again from zero.
- R10: If gap_hi drops before HOLD_CYC cycles have passed, done does not rise and the block restarts as in R9, with group 2 first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arc_det | input | 1 | Arc voltage detected across the contacts |
| g1_block | input | 1 | Group-1 thyristors are blocking |
| sup_ok | input | 1 | Control supply is valid |
| gap_hi | input | 1 | Gap voltage is above the high-voltage threshold |
| fire_g1 | output | 1 | Gate pulse for group 1 (charge) |
| fire_g2 | output | 1 | Gate pulse for group 2 (discharge and reversal) |
| done | output | 1 | Interruption confirmed |
| fail | output | 1 | Sequence stopped on timeout or supply loss |

## Verification
The bench builds the block with these parameters:

| Parameter | Bench value |
|-----------|-------------|
| DEAD_CYC | 20 |
| PULSE_CYC | 3 |
| HALF_CYC | 5 |
| BLK_TMO_CYC | 4 |
| MAX_PAIRS | 3 |
| HOLD_CYC | 6 |

With these values a whole pumping attempt, including its pair-limit timeout, fits in under a hundred cycles. Every firing edge can therefore be predicted to the exact cycle from the sums of the intervals. Choosing MAX_PAIRS of 3 lets one pair complete before success. A pair counter that is not cleared on restrike then fails 17 cycles early. Choosing HOLD_CYC of 6 leaves room to drop gap_hi inside the confirmation window and to cut a group-1 pulse short.

// File: rtl/inj_seq_pkg.sv
package inj_seq_pkg;

  typedef enum logic [3:0] {
    SEQ_IDLE,
    SEQ_DEAD,
    SEQ_G1P,
    SEQ_G1W,
    SEQ_BLK,
    SEQ_G2P,
    SEQ_G2W,
    SEQ_CONF,
    SEQ_DONE,
    SEQ_FAIL
  } seq_st_t;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // interval length that a timed state lasts; untimed states use 1
  function automatic int unsigned state_lim(input seq_st_t s,
                                            input int unsigned dead,
                                            input int unsigned pulse,
                                            input int unsigned half,
                                            input int unsigned btmo,
                                            input int unsigned hold);
    case (s)
      SEQ_DEAD:          return dead;
      SEQ_G1P, SEQ_G2P:  return pulse;
      SEQ_G1W, SEQ_G2W:  return half;
      SEQ_BLK:           return btmo;
      SEQ_CONF:          return hold;
      default:           return 1;
    endcase
  endfunction

endpackage

// File: rtl/inj_seq_timer.sv
module inj_seq_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] lim,
  output logic          expire
);
  logic [CW-1:0] cnt;

  // expires on the last cycle of an interval of lim cycles, then holds
  assign expire = (cnt == lim - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (!expire) cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/inj_seq_pairs.sv
module inj_seq_pairs #(
  parameter int unsigned MAXP = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int unsigned PW = $clog2(MAXP + 1);
  logic [PW-1:0] n;

  assign last = (n == PW'(MAXP - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    n <= '0;
    else if (clr)  n <= '0;
    else if (inc)  n <= n + PW'(1);
  end
endmodule

// File: rtl/inj_fire_seq.sv
module inj_fire_seq #(
  parameter int unsigned DEAD_CYC    = 200000,
  parameter int unsigned PULSE_CYC   = 50,
  parameter int unsigned HALF_CYC    = 1000,
  parameter int unsigned BLK_TMO_CYC = 500,
  parameter int unsigned MAX_PAIRS   = 8,
  parameter int unsigned HOLD_CYC    = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arc_det,
  input  logic g1_block,
  input  logic sup_ok,
  input  logic gap_hi,
  output logic fire_g1,
  output logic fire_g2,
  output logic done,
  output logic fail
);
  import inj_seq_pkg::*;

  localparam int unsigned MAXLIM = max_of(max_of(DEAD_CYC, PULSE_CYC),
                                          max_of(max_of(HALF_CYC, BLK_TMO_CYC), HOLD_CYC));
  localparam int unsigned CW = $clog2(MAXLIM + 1);

  seq_st_t       st, st_nxt;
  logic [CW-1:0] tlim;
  logic          t_exp;
  logic          p_last;

  // named internal events
  logic seq_busy;
  logic seq_active;
  logic ev_stop_sup;
  logic ev_confirm;
  logic ev_restrike;
  logic ev_blk_ok;
  logic ev_pair_end;

  assign seq_busy    = (st == SEQ_DEAD) || (st == SEQ_G1P) || (st == SEQ_G1W) ||
                       (st == SEQ_BLK)  || (st == SEQ_G2P) || (st == SEQ_G2W);
  assign seq_active  = seq_busy || (st == SEQ_CONF) || (st == SEQ_DONE);
  assign ev_stop_sup = seq_active && !sup_ok;
  assign ev_confirm  = seq_busy && gap_hi;
  assign ev_restrike = ((st == SEQ_CONF) || (st == SEQ_DONE)) && !gap_hi;
  assign ev_blk_ok   = (st == SEQ_BLK) && g1_block;
  assign ev_pair_end = (st == SEQ_G2W) && t_exp;

  assign tlim = CW'(state_lim(st, DEAD_CYC, PULSE_CYC, HALF_CYC, BLK_TMO_CYC, HOLD_CYC));

  always_comb begin
    st_nxt = st;
    if (ev_stop_sup)       st_nxt = SEQ_FAIL;
    else if (ev_confirm)   st_nxt = SEQ_CONF;
    else if (ev_restrike)  st_nxt = SEQ_G2P;
    else begin
      case (st)
        SEQ_IDLE: if (arc_det && sup_ok) st_nxt = SEQ_DEAD;
        SEQ_DEAD: if (t_exp) st_nxt = SEQ_G1P;
        SEQ_G1P:  if (t_exp) st_nxt = SEQ_G1W;
        SEQ_G1W:  if (t_exp) st_nxt = SEQ_BLK;
        SEQ_BLK: begin
          if (g1_block)   st_nxt = SEQ_G2P;
          else if (t_exp) st_nxt = SEQ_FAIL;
        end
        SEQ_G2P:  if (t_exp) st_nxt = SEQ_G2W;
        SEQ_G2W:  if (t_exp) st_nxt = p_last ? SEQ_FAIL : SEQ_G1P;
        SEQ_CONF: if (t_exp) st_nxt = SEQ_DONE;
        default:  st_nxt = st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= SEQ_IDLE;
    else        st <= st_nxt;
  end

  inj_seq_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (st_nxt != st),
    .lim    (tlim),
    .expire (t_exp)
  );

  inj_seq_pairs #(.MAXP(MAX_PAIRS)) u_pairs (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   ((st == SEQ_IDLE) || ev_restrike),
    .inc   (ev_pair_end),
    .last  (p_last)
  );

  assign fire_g1 = (st == SEQ_G1P);
  assign fire_g2 = (st == SEQ_G2P);
  assign done    = (st == SEQ_DONE);
  assign fail    = (st == SEQ_FAIL);
endmodule

// File: rtl/inj_fire_seq_chk.sv
module inj_fire_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic sup_ok,
  input logic gap_hi,
  input logic fire_g1,
  input logic fire_g2,
  input logic done,
  input logic fail,
  input logic seq_busy,
  input logic ev_blk_ok,
  input logic ev_restrike
);
  // R4
  one_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire_g1 && fire_g2));

  // R4
  g2_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fire_g2) |-> $past(ev_blk_ok || ev_restrike));

  // R7
  sup_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && !sup_ok) |=> fail);

  // R7
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> fail);

  // R8
  stop_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && sup_ok && gap_hi) |=> (!fire_g1 && !fire_g2));

  // R9
  done_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(gap_hi));

  // R1
  out_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fire_g1, fire_g2, done, fail}));
endmodule

bind inj_fire_seq inj_fire_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sup_ok      (sup_ok),
  .gap_hi      (gap_hi),
  .fire_g1     (fire_g1),
  .fire_g2     (fire_g2),
  .done        (done),
  .fail        (fail),
  .seq_busy    (seq_busy),
  .ev_blk_ok   (ev_blk_ok),
  .ev_restrike (ev_restrike)
);

// File: tb/sim_inj_fire_seq.sv
module sim_inj_fire_seq;
  localparam int unsigned D  = 20;
  localparam int unsigned P  = 3;
  localparam int unsigned H  = 5;
  localparam int unsigned BT = 4;
  localparam int unsigned MP = 3;
  localparam int unsigned HD = 6;
  // kinds of observed rising edges
  localparam int K_G1 = 1, K_G2 = 2, K_DONE = 3, K_FAIL = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic arc_det = 1'b0, g1_block = 1'b1, sup_ok = 1'b1, gap_hi = 1'b0;
  logic fire_g1, fire_g2, done, fail;

  inj_fire_seq #(.DEAD_CYC(D), .PULSE_CYC(P), .HALF_CYC(H),
                 .BLK_TMO_CYC(BT), .MAX_PAIRS(MP), .HOLD_CYC(HD)) u0 (
    .clk(clk), .rst_n(rst_n), .arc_det(arc_det), .g1_block(g1_block),
    .sup_ok(sup_ok), .gap_hi(gap_hi), .fire_g1(fire_g1), .fire_g2(fire_g2),
    .done(done), .fail(fail));

  always #2 clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, failures = 0;
  bit ended = 1'b0;
  int exp_kind[$];
  int unsigned exp_cyc[$];
  string exp_req[$];

  task automatic expect_ev(input int kind, input int unsigned c, input string req);
    exp_kind.push_back(kind);
    exp_cyc.push_back(c);
    exp_req.push_back(req);
  endtask

  task automatic got(input int kind);
    int ek;
    int unsigned ec;
    string rq;
    checks++;
    if (exp_kind.size() == 0) begin
      failures++;
      $display("FAIL R6 unexpected event: actual kind=%0d cyc=%0d expected none", kind, cyc);
    end else begin
      ek = exp_kind.pop_front();
      ec = exp_cyc.pop_front();
      rq = exp_req.pop_front();
      if (ek != kind || ec != cyc) begin
        failures++;
        $display("FAIL %s event: actual kind=%0d cyc=%0d expected kind=%0d cyc=%0d",
                 rq, kind, cyc, ek, ec);
      end
    end
  endtask

  // monitor: compares rising output edges against the expected queue
  logic p1 = 1'b0, p2 = 1'b0, pd = 1'b0, pf = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (fire_g1 && !p1) got(K_G1);
      if (fire_g2 && !p2) got(K_G2);
      if (done && !pd)    got(K_DONE);
      if (fail && !pf)    got(K_FAIL);
    end
    p1 <= fire_g1; p2 <= fire_g2; pd <= done; pf <= fail;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s at cyc %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic to_cyc(input int unsigned t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic drain(input string req);
    int n = 0;
    while (exp_kind.size() != 0 && n < 300) begin
      @(negedge clk);
      n++;
    end
    checks++;
    if (exp_kind.size() != 0) begin
      failures++;
      $display("FAIL %s pending events: actual=%0d expected=0", req, exp_kind.size());
      exp_kind.delete(); exp_cyc.delete(); exp_req.delete();
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; arc_det = 1'b0; gap_hi = 1'b0; sup_ok = 1'b1; g1_block = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    ended = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      failures++;
      $display("FAIL R6 watchdog expired: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned t0, y, r;
    do_reset();
    // R1 reset state
    chk({fire_g1, fire_g2, done, fail} == 4'b0000, "R1", {fire_g1, fire_g2, done, fail}, 0);

    // R2 arc ignored while supply is low
    sup_ok = 1'b0; arc_det = 1'b1;
    repeat (30) @(negedge clk);
    chk({fire_g1, fire_g2, done, fail} == 4'b0000, "R2", {fire_g1, fire_g2, done, fail}, 0);

    // R2 R4 R6 full attempt ending on the pair limit
    sup_ok = 1'b1; t0 = cyc + 1;
    expect_ev(K_G1, t0 + D, "R2");
    for (int k = 0; k < MP; k++) begin
      if (k > 0) expect_ev(K_G1, t0 + D + k * (2*P + 2*H + 1), "R6");
      expect_ev(K_G2, t0 + D + P + H + 1 + k * (2*P + 2*H + 1), "R4");
    end
    expect_ev(K_FAIL, t0 + D + MP * (2*P + 2*H + 1), "R6");
    to_cyc(t0 + D + P - 1);     chk(fire_g1 == 1'b1, "R3", fire_g1, 1);
    to_cyc(t0 + D + P);         chk(fire_g1 == 1'b0, "R3", fire_g1, 0);
    to_cyc(t0 + D + 2*P + H);   chk(fire_g2 == 1'b1, "R3", fire_g2, 1);
    to_cyc(t0 + D + 2*P + H + 1); chk(fire_g2 == 1'b0, "R3", fire_g2, 0);
    drain("R6");

    // R5 blocking check timeout
    do_reset();
    g1_block = 1'b0; arc_det = 1'b1; t0 = cyc + 1;
    expect_ev(K_G1, t0 + D, "R5");
    expect_ev(K_FAIL, t0 + D + P + H + BT, "R5");
    drain("R5");
    repeat (5) @(negedge clk);
    chk(fire_g2 == 1'b0 && fail == 1'b1, "R5", {fire_g2, fail}, 1);

    // R8 success, then R9 restrike with group 2 first and fresh pair count
    do_reset();
    arc_det = 1'b1; t0 = cyc + 1;
    expect_ev(K_G1, t0 + D, "R8");
    expect_ev(K_G2, t0 + D + P + H + 1, "R8");
    expect_ev(K_G1, t0 + D + 2*P + 2*H + 1, "R8");
    expect_ev(K_DONE, t0 + D + 2*P + 2*H + 1 + P + 1 + HD, "R8");
    to_cyc(t0 + D + 2*P + 2*H + 1 + P);
    gap_hi = 1'b1;
    drain("R8");
    repeat (3) @(negedge clk);
    chk(done == 1'b1 && fire_g1 == 1'b0 && fire_g2 == 1'b0, "R8",
        {done, fire_g1, fire_g2}, 4);
    y = cyc; r = y + 1;
    gap_hi = 1'b0;
    expect_ev(K_G2, r, "R9");
    expect_ev(K_G1, r + P + H, "R9");
    expect_ev(K_G2, r + 2*P + 2*H + 1, "R9");
    expect_ev(K_G1, r + 2*P + 2*H + 1 + P + H, "R9");
    expect_ev(K_G2, r + 2*(2*P + 2*H + 1), "R9");
    expect_ev(K_FAIL, r + 2*(2*P + 2*H + 1) + P + H, "R9");
    to_cyc(r);
    chk(done == 1'b0, "R9", done, 0);
    drain("R9");

    // R10 short confirmation, R8 pulse cut short, R7 supply loss
    do_reset();
    arc_det = 1'b1; t0 = cyc + 1;
    expect_ev(K_G1, t0 + D, "R10");
    expect_ev(K_G2, t0 + D + 5, "R10");
    expect_ev(K_G1, t0 + D + 5 + P + H, "R10");
    expect_ev(K_FAIL, t0 + D + 5 + P + H + 3, "R7");
    to_cyc(t0 + D + 1);
    gap_hi = 1'b1;
    to_cyc(t0 + D + 2);
    chk(fire_g1 == 1'b0, "R8", fire_g1, 0);
    to_cyc(t0 + D + 4);
    gap_hi = 1'b0;
    to_cyc(t0 + D + 5 + P + H + 2);
    sup_ok = 1'b0;
    drain("R10");

    // R7 supply loss during dead time, fail held
    do_reset();
    arc_det = 1'b1; t0 = cyc + 1;
    expect_ev(K_FAIL, t0 + 6, "R7");
    to_cyc(t0 + 5);
    sup_ok = 1'b0;
    drain("R7");
    sup_ok = 1'b1;
    repeat (10) @(negedge clk);
    chk(fail == 1'b1, "R7", fail, 1);

    summary();
    $finish;
  end
endmodule